// File: doc/BRIEF.md
# Two-Tier Masked Priority Interrupt Selector

This block decides, at each instruction boundary, which interrupt source a small CPU core services next. It reads a 32-bit mask of pending sources together with the core's two condition-code mask flags: I gates the ordinary peripheral sources and X gates the high-priority external request. It then produces a one-cycle take pulse, the selected source index and the address of that source's vector-table slot. When it takes a source, it also tells the core which mask flag to raise on entry. For the sources that are cleared automatically when taken, it returns a one-hot acknowledge. The core saves its registers and fetches the vector itself.

Selection runs in three tiers. The software trap and the illegal-opcode trap cannot be masked and are checked first, in that order. The external high-priority request comes next and is gated only by X. While that request is pending and X is set, it blocks every source below it. All remaining sources are gated by I. Among them the block walks a programmable order table from slot 0 upward and takes the first pending source. The vector base depends on the operating mode: normal or bootstrap.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, take_o, ack_o, set_i_o, set_x_o, svc_cycles_o, take_idx_o and vec_addr_o are all zero, and the order table holds the identity mapping (slot k holds source k).
- R2: An evaluation with an all-zero pending mask takes nothing.
- R3: Source 27 (software trap) wins over everything, and source 28 (illegal opcode) comes second. Both are taken regardless of I and X, and taking either one asserts the matching bit of ack_o.
- R4: If source 26 (high-priority external request) is pending and X is 0, it is taken and bit 26 of ack_o is asserted. If it is pending while X is 1 and neither trap is pending, nothing is taken, whatever I and the other bits are.
- R5: With I equal to 1, no source outside 26, 27 and 28 is taken.
- R6: Otherwise the block takes the source named by the lowest order-table slot whose source is pending. With the identity table, that is the lowest pending index.
- R7: A write with tbl_we_i set stores tbl_value_i into slot tbl_entry_i at the clock edge. The new order applies from the next evaluation onward.
- R8: Taking a source outside 26, 27 and 28 leaves ack_o all zero. The same source is taken again at the next boundary if it is still pending.
- R9: vec_addr_o equals the base plus twice the index, modulo 2^16. The base is 0xFFC0 when special_mode_i is 0 and 0xBFC0 when it is 1.
- R10: A take through source 26 asserts set_x_o. Any other take asserts set_i_o. Exactly one of the two accompanies each take.
- R11: svc_cycles_o reads 14 in the cycle of a take and 0 otherwise.
- R12: An evaluation happens only on a clock edge where boundary_i is 1. Its results appear in the following cycle, and take_o stays high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | One-cycle instruction-boundary strobe that triggers an evaluation |
| pending_i | input | 32 | Pending mask, bit k = source k |
| mask_i_i | input | 1 | Core's I mask flag |
| mask_x_i | input | 1 | Core's X mask flag |
| special_mode_i | input | 1 | 1 selects the bootstrap vector base |
| tbl_we_i | input | 1 | Order-table write enable |
| tbl_entry_i | input | 5 | Order-table slot to write |
| tbl_value_i | input | 5 | Source index written into the slot |
| take_o | output | 1 | One-cycle pulse: a source was selected |
| take_idx_o | output | 5 | Index of the selected source |
| vec_addr_o | output | 16 | Vector-table slot address for the selected source |
| set_i_o | output | 1 | Core must set I on entry |
| set_x_o | output | 1 | Core must set X on entry |
| ack_o | output | 32 | One-hot clear for an auto-cleared source |
| svc_cycles_o | output | 4 | Cycle cost of the entry sequence |

## Verification
The bench builds the block with its default parameters: 32 sources, 5-bit indices, 16-bit addresses, trap indices 27 and 28, and the external request at 26. With these values the highest source index, 31, is reachable through the identity table, so the vector arithmetic is checked at 0xFFFE. Both bases can be reached at the true index positions, so the bootstrap base gives 0xBFD6 and 0xBFF4. A reprogrammed slot 0 shows the order table overriding numeric priority.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    TIER_NONE     = 2'd0,
    TIER_FIXED    = 2'd1,
    TIER_XGATED   = 2'd2,
    TIER_MASKABLE = 2'd3
  } tier_e;
endpackage

// File: rtl/irq_order_table.sv
module irq_order_table #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         wr_slot,
  input  logic [IDX_W-1:0]         wr_src,
  output logic [NUM_SRC*IDX_W-1:0] order_flat
);
  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_slot
      logic [IDX_W-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          slot_q <= IDX_W'(s);
        else if (we && (wr_slot == IDX_W'(s)))
          slot_q <= wr_src;
      end
      assign order_flat[s*IDX_W +: IDX_W] = slot_q;
    end
  endgenerate
endmodule

// File: rtl/irq_order_scan.sv
module irq_order_scan #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC*IDX_W-1:0] order_flat,
  input  logic [NUM_SRC-1:0]       pending,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pending[order_flat[k*IDX_W +: IDX_W]]) begin
        hit     = 1'b1;
        hit_idx = order_flat[k*IDX_W +: IDX_W];
      end
    end
  end
endmodule

// File: rtl/irq_tier_select.sv
module irq_tier_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int IDX_W    = 5,
  parameter int SWI_IDX  = 27,
  parameter int ILL_IDX  = 28,
  parameter int XIRQ_IDX = 26
) (
  input  logic [NUM_SRC-1:0] pending,
  input  logic               mask_i,
  input  logic               mask_x,
  input  logic               scan_hit,
  input  logic [IDX_W-1:0]   scan_idx,
  output tier_e              tier,
  output logic [IDX_W-1:0]   pick_idx,
  output logic [NUM_SRC-1:0] pick_ack
);
  always_comb begin
    tier     = TIER_NONE;
    pick_idx = '0;
    pick_ack = '0;
    if (pending[SWI_IDX]) begin
      tier     = TIER_FIXED;
      pick_idx = IDX_W'(SWI_IDX);
      pick_ack[SWI_IDX] = 1'b1;
    end else if (pending[ILL_IDX]) begin
      tier     = TIER_FIXED;
      pick_idx = IDX_W'(ILL_IDX);
      pick_ack[ILL_IDX] = 1'b1;
    end else if (pending[XIRQ_IDX]) begin
      if (!mask_x) begin
        tier     = TIER_XGATED;
        pick_idx = IDX_W'(XIRQ_IDX);
        pick_ack[XIRQ_IDX] = 1'b1;
      end
    end else if (!mask_i && scan_hit) begin
      tier     = TIER_MASKABLE;
      pick_idx = scan_idx;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int          NUM_SRC        = 32,
  parameter int          ADDR_W         = 16,
  parameter int          SWI_IDX        = 27,
  parameter int          ILL_IDX        = 28,
  parameter int          XIRQ_IDX       = 26,
  parameter logic [15:0] BASE_NORMAL    = 16'hFFC0,
  parameter logic [15:0] BASE_SPECIAL   = 16'hBFC0,
  parameter int          SERVICE_CYCLES = 14,
  localparam int         IDX_W          = $clog2(NUM_SRC),
  localparam int         SVC_W          = $clog2(SERVICE_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary_i,
  input  logic [NUM_SRC-1:0] pending_i,
  input  logic               mask_i_i,
  input  logic               mask_x_i,
  input  logic               special_mode_i,
  input  logic               tbl_we_i,
  input  logic [IDX_W-1:0]   tbl_entry_i,
  input  logic [IDX_W-1:0]   tbl_value_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   take_idx_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic               set_i_o,
  output logic               set_x_o,
  output logic [NUM_SRC-1:0] ack_o,
  output logic [SVC_W-1:0]   svc_cycles_o
);
  function automatic logic [ADDR_W-1:0] slot_addr(input logic special,
                                                  input logic [IDX_W-1:0] idx);
    logic [ADDR_W-1:0] base;
    base = special ? ADDR_W'(BASE_SPECIAL) : ADDR_W'(BASE_NORMAL);
    return base + (ADDR_W'(idx) << 1);
  endfunction

  logic [NUM_SRC*IDX_W-1:0] order_flat;
  logic                     scan_hit;
  logic [IDX_W-1:0]         scan_idx;
  tier_e                    tier;
  logic [IDX_W-1:0]         pick_idx;
  logic [NUM_SRC-1:0]       pick_ack;
  logic                     fire;
  logic                     fire_xgated;

  irq_order_table #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (tbl_we_i),
    .wr_slot    (tbl_entry_i),
    .wr_src     (tbl_value_i),
    .order_flat (order_flat)
  );

  irq_order_scan #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_scan (
    .order_flat (order_flat),
    .pending    (pending_i),
    .hit        (scan_hit),
    .hit_idx    (scan_idx)
  );

  irq_tier_select #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W),
    .SWI_IDX(SWI_IDX), .ILL_IDX(ILL_IDX), .XIRQ_IDX(XIRQ_IDX)
  ) u_tier (
    .pending  (pending_i),
    .mask_i   (mask_i_i),
    .mask_x   (mask_x_i),
    .scan_hit (scan_hit),
    .scan_idx (scan_idx),
    .tier     (tier),
    .pick_idx (pick_idx),
    .pick_ack (pick_ack)
  );

  assign fire        = boundary_i && (tier != TIER_NONE);
  assign fire_xgated = fire && (tier == TIER_XGATED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o       <= 1'b0;
      take_idx_o   <= '0;
      vec_addr_o   <= '0;
      set_i_o      <= 1'b0;
      set_x_o      <= 1'b0;
      ack_o        <= '0;
      svc_cycles_o <= '0;
    end else begin
      take_o       <= fire;
      set_x_o      <= fire_xgated;
      set_i_o      <= fire && !fire_xgated;
      ack_o        <= fire ? pick_ack : '0;
      svc_cycles_o <= fire ? SVC_W'(SERVICE_CYCLES) : '0;
      if (fire) begin
        take_idx_o <= pick_idx;
        vec_addr_o <= slot_addr(special_mode_i, pick_idx);
      end
    end
  end

  AST_NO_STROBE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> !take_o); // R12
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && pending_i == '0) |=> !take_o); // R2
  AST_XGATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && pending_i[XIRQ_IDX] && mask_x_i && !pending_i[SWI_IDX]
     && !pending_i[ILL_IDX]) |=> !take_o); // R4
  AST_IMASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && mask_i_i && !pending_i[SWI_IDX] && !pending_i[ILL_IDX]
     && !pending_i[XIRQ_IDX]) |=> !take_o); // R5
  AST_ONE_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($countones({set_i_o, set_x_o}) == 1)); // R10
  AST_ACK_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o != '0) |-> (take_o && $countones(ack_o) == 1)); // R3
  AST_SWI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && pending_i[SWI_IDX]) |=> (take_o && take_idx_o == IDX_W'(SWI_IDX))); // R3
  AST_SVC_COST: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (svc_cycles_o == SVC_W'(SERVICE_CYCLES))); // R11
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(boundary_i, 2)) |=> !take_o || $past(boundary_i)); // R12
endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 1'b0;
  logic [31:0] pending_i = '0;
  logic        mask_i_i = 1'b0;
  logic        mask_x_i = 1'b0;
  logic        special_mode_i = 1'b0;
  logic        tbl_we_i = 1'b0;
  logic [4:0]  tbl_entry_i = '0;
  logic [4:0]  tbl_value_i = '0;
  logic        take_o;
  logic [4:0]  take_idx_o;
  logic [15:0] vec_addr_o;
  logic        set_i_o;
  logic        set_x_o;
  logic [31:0] ack_o;
  logic [3:0]  svc_cycles_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [4:0] order_m [32];

  always #10 clk = ~clk;

  irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .pending_i(pending_i),
    .mask_i_i(mask_i_i), .mask_x_i(mask_x_i), .special_mode_i(special_mode_i),
    .tbl_we_i(tbl_we_i), .tbl_entry_i(tbl_entry_i), .tbl_value_i(tbl_value_i),
    .take_o(take_o), .take_idx_o(take_idx_o), .vec_addr_o(vec_addr_o),
    .set_i_o(set_i_o), .set_x_o(set_x_o), .ack_o(ack_o), .svc_cycles_o(svc_cycles_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Independent model of the selection rules.
  task automatic model(input logic [31:0] p, input logic ib, input logic xb,
                       output logic tk, output logic [4:0] ix);
    tk = 1'b0; ix = '0;
    if (p[27]) begin tk = 1'b1; ix = 5'd27; end
    else if (p[28]) begin tk = 1'b1; ix = 5'd28; end
    else if (p[26]) begin
      if (!xb) begin tk = 1'b1; ix = 5'd26; end
    end else if (!ib) begin
      for (int k = 0; k < 32; k++)
        if (!tk && p[order_m[k]]) begin tk = 1'b1; ix = order_m[k]; end
    end
  endtask

  task automatic eval(input string req, input logic [31:0] p, input logic ib,
                      input logic xb, input logic sp);
    logic tk;
    logic [4:0] ix;
    logic [15:0] ea;
    logic [31:0] eack;
    model(p, ib, xb, tk, ix);
    ea = (sp ? 16'hBFC0 : 16'hFFC0) + {10'd0, ix, 1'b0};
    eack = (tk && (ix == 5'd26 || ix == 5'd27 || ix == 5'd28)) ? (32'd1 << ix) : 32'd0;
    @(negedge clk);
    pending_i = p; mask_i_i = ib; mask_x_i = xb; special_mode_i = sp;
    boundary_i = 1'b1;
    @(negedge clk);
    boundary_i = 1'b0;
    chk(req, "take", {31'd0, take_o}, {31'd0, tk});
    if (tk) begin
      chk(req, "index", {27'd0, take_idx_o}, {27'd0, ix});
      chk("R9", "vector", {16'd0, vec_addr_o}, {16'd0, ea});
      chk("R10", "set_x", {31'd0, set_x_o}, {31'd0, ix == 5'd26});
      chk("R10", "set_i", {31'd0, set_i_o}, {31'd0, ix != 5'd26});
      chk("R11", "svc", {28'd0, svc_cycles_o}, 32'd14);
    end else begin
      chk("R11", "svc idle", {28'd0, svc_cycles_o}, 32'd0);
    end
    chk(req, "ack", ack_o, eack);
    @(negedge clk);
    chk("R12", "pulse ends", {31'd0, take_o}, 32'd0);
  endtask

  task automatic write_slot(input logic [4:0] s, input logic [4:0] v);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_entry_i = s; tbl_value_i = v;
    @(negedge clk);
    tbl_we_i = 1'b0;
    order_m[s] = v;
  endtask

  task automatic t_reset;
    chk("R1", "take", {31'd0, take_o}, 32'd0);
    chk("R1", "index", {27'd0, take_idx_o}, 32'd0);
    chk("R1", "vector", {16'd0, vec_addr_o}, 32'd0);
    chk("R1", "ack", ack_o, 32'd0);
    chk("R1", "masks", {30'd0, set_i_o, set_x_o}, 32'd0);
    chk("R1", "svc", {28'd0, svc_cycles_o}, 32'd0);
    eval("R1", 32'h0000_0006, 1'b0, 1'b0, 1'b0); // identity: source 1 first
  endtask

  task automatic t_empty;
    eval("R2", 32'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    pending_i = 32'h0000_0010; mask_i_i = 1'b0; mask_x_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12", "no strobe", {31'd0, take_o}, 32'd0);
  endtask

  task automatic t_fixed;
    eval("R3", (32'd1 << 27) | (32'd1 << 28) | 32'h20, 1'b1, 1'b1, 1'b0);
    eval("R3", (32'd1 << 28) | (32'd1 << 26) | 32'h8, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_xgate;
    eval("R4", (32'd1 << 26) | 32'h4, 1'b1, 1'b0, 1'b0);
    eval("R4", (32'd1 << 26) | 32'h4, 1'b0, 1'b1, 1'b0);
    eval("R4", (32'd1 << 26), 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_imask;
    eval("R5", 32'h0000_0008, 1'b1, 1'b0, 1'b0);
    eval("R6", 32'h0000_0008, 1'b0, 1'b0, 1'b0);
    eval("R6", (32'd1 << 31) | (32'd1 << 17) | (32'd1 << 9), 1'b0, 1'b0, 1'b0);
    eval("R6", (32'd1 << 31), 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_table;
    write_slot(5'd0, 5'd20);
    eval("R7", (32'd1 << 20) | 32'h2, 1'b0, 1'b0, 1'b0);
    write_slot(5'd0, 5'd0);
    eval("R7", (32'd1 << 20) | 32'h2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_refire;
    eval("R8", 32'h0000_0010, 1'b0, 1'b0, 1'b0);
    eval("R8", 32'h0000_0010, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_vector;
    eval("R9", (32'd1 << 11), 1'b0, 1'b0, 1'b1);
    eval("R9", (32'd1 << 31), 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) order_m[k] = 5'(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_empty;
    t_fixed;
    t_xgate;
    t_imask;
    t_table;
    t_refire;
    t_vector;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule